// File: doc/BRIEF.md
# Burst Write Command Buffer

This block sits between a 32-bit CPU bus, on which the address and the data share one set of wires, and the chip's internal memory path. It absorbs posted writes so the CPU can move on before memory has taken them. A write starts with a command cycle that carries the address and a length code. The data words then follow on the same wires, one per clock, with no idle cycles between them.

Four entries are available. An entry is claimed when its command is accepted. It holds the start address, a burst flag, a word count, and a data word with byte enables for each of four lanes. The entry becomes visible to the consumer only once its last word has been written. The consumer takes whole entries in arrival order through a valid/ready handshake. A command with an unsupported length is refused and flagged, and no entry is claimed for it.

Top module: `wr_cmd_buf`

## Requirements
- R1: At most four entries are held. `cpu_ready` is low while all four are occupied, and it goes high in the cycle after the handshake that drains one of them.
- R2: A single-word write (length code 0) gives an entry with `drn_words` = 1 and `drn_burst` = 0. Its data and enables sit in lane 0 (bits 31:0 and 3:0). All other lanes read as zero data and zero enables.
- R3: A burst (length code 1) gives an entry with `drn_words` = 4 and `drn_burst` = 1. Data word k goes to lane k (bits 32k+31:32k, enables 4k+3:4k), and lane k stands for address base + 4k.
- R4: For a burst, the stored address has bits 3:0 forced to zero, which aligns it to 16 bytes. A single write keeps its address unchanged.
- R5: Data words are taken in consecutive cycles. The k-th cycle with `cpu_dat_valid` after the command fills lane k-1.
- R6: Length codes 2 (eight words) and 3 (reserved) are refused. `cpu_unsup` is high for one cycle, in the cycle after the command, and no entry is claimed.
- R7: Entries drain strictly first-in first-out. `drn_valid` rises only after the entry's last data word has been written.
- R8: When a command is accepted in the same cycle as a drain handshake, the occupancy does not change.
- R9: After reset, `cpu_ready` = 1, `drn_valid` = 0 and `cpu_unsup` = 0.
- R10: While `drn_valid` is high and `drn_ready` is low, the presented entry stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_cmd_valid | input | 1 | Command cycle; `cpu_ad` carries the address |
| cpu_len | input | 2 | Length code: 0 single, 1 four-word burst, 2 eight-word, 3 reserved |
| cpu_dat_valid | input | 1 | Data cycle; `cpu_ad` carries a data word |
| cpu_ad | input | 32 | Shared address/data bus |
| cpu_be | input | 4 | Byte enables for the current data word |
| cpu_ready | output | 1 | A new command may be issued |
| cpu_unsup | output | 1 | One-cycle flag for a refused length code |
| drn_valid | output | 1 | The head entry is complete and presented |
| drn_ready | input | 1 | The consumer takes the head entry |
| drn_addr | output | 32 | Start address of the head entry |
| drn_burst | output | 1 | The head entry is a burst |
| drn_words | output | 3 | Number of words written into the head entry |
| drn_be | output | 16 | Byte enables, four bits per lane |
| drn_data | output | 128 | Data, 32 bits per lane |

## Verification
The bench fills all four entries while the consumer stalls. A design that counted occupancy wrongly would keep `cpu_ready` high and overwrite the oldest entry. The bench then drains one entry, and a design with an off-by-one in its ready path would hold off the CPU for one cycle too many. The bench also lines up a command acceptance with a drain handshake. A design that let one update override the other would drift by one entry, either stalling early or overrunning. Further tests use unaligned burst addresses, which a missing mask would pass through unchanged. Refused length codes are sent while the buffer is full; a design that claimed an entry for them would show up through the ready line and the drain order. A long stretch with random consumer back-pressure shows any reordering or early exposure of a half-written entry.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  parameter int BUS_W = 32;

  typedef enum logic [1:0] {
    LEN_ONE   = 2'd0,
    LEN_FOUR  = 2'd1,
    LEN_EIGHT = 2'd2,
    LEN_RSVD  = 2'd3
  } len_e;

  // burst addresses lose their offset inside one entry-sized block
  function automatic logic [BUS_W-1:0] align_base(input logic [BUS_W-1:0] a,
                                                  input logic burst,
                                                  input int low_bits);
    logic [BUS_W-1:0] keep;
    keep = ~((BUS_W'(1) << low_bits) - BUS_W'(1));
    return burst ? (a & keep) : a;
  endfunction

  function automatic logic lane_is_last(input logic burst, input int lane, input int words);
    return !burst || (lane == words - 1);
  endfunction

  function automatic int ptr_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wcb_ingest.sv
module wcb_ingest import wcb_pkg::*; #(
  parameter int WORDS = 4,
  localparam int LW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_len,
  input  logic          dat_valid,
  input  logic          space_ok,
  output logic          cpu_ready,
  output logic          cpu_unsup,
  output logic          alloc_o,
  output logic          burst_o,
  output logic          word_we_o,
  output logic [LW-1:0] lane_o,
  output logic          last_o
);

  len_e          len_w;
  logic          filling_q;
  logic          burst_q;
  logic          unsup_q;
  logic [LW-1:0] lane_q;
  logic          len_ok;
  logic          cmd_bad;

  assign len_w     = len_e'(cmd_len);
  assign len_ok    = (len_w == LEN_ONE) || (len_w == LEN_FOUR);
  assign cpu_ready = space_ok && !filling_q;
  assign alloc_o   = cmd_valid && cpu_ready && len_ok;
  assign cmd_bad   = cmd_valid && !filling_q && !len_ok;
  assign burst_o   = (len_w == LEN_FOUR);
  assign word_we_o = filling_q && dat_valid;
  assign lane_o    = lane_q;
  assign last_o    = word_we_o && lane_is_last(burst_q, int'(lane_q), WORDS);
  assign cpu_unsup = unsup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filling_q <= 1'b0;
      burst_q   <= 1'b0;
      unsup_q   <= 1'b0;
      lane_q    <= '0;
    end else begin
      unsup_q <= cmd_bad;
      if (alloc_o) begin
        filling_q <= 1'b1;
        burst_q   <= burst_o;
        lane_q    <= '0;
      end else if (word_we_o) begin
        lane_q <= lane_q + 1'b1;
        if (last_o) filling_q <= 1'b0;
      end
    end
  end

  // R5: once a command is taken, its words come back to back
  a_r5_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_o |=> dat_valid);
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we_o && !last_o) |=> dat_valid);
  // R6: a refused length never opens a fill
  a_r6_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> !filling_q);

endmodule

// File: rtl/wcb_store.sv
module wcb_store import wcb_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int NW = $clog2(WORDS + 1),
  localparam int BW = DW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_i,
  input  logic                burst_i,
  input  logic [DW-1:0]       addr_i,
  input  logic                word_we_i,
  input  logic [LW-1:0]       lane_i,
  input  logic                last_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [BW-1:0]       wbe_i,
  output logic                space_ok_o,
  output logic [CW-1:0]       occ_o,
  output logic                drain_o,
  output logic                drn_valid,
  input  logic                drn_ready,
  output logic [DW-1:0]       drn_addr,
  output logic                drn_burst,
  output logic [NW-1:0]       drn_words,
  output logic [WORDS*BW-1:0] drn_be,
  output logic [WORDS*DW-1:0] drn_data
);

  logic [DW-1:0]    addr_q [DEPTH];
  logic [NW-1:0]    cnt_q  [DEPTH];
  logic [DW-1:0]    data_q [DEPTH][WORDS];
  logic [BW-1:0]    be_q   [DEPTH][WORDS];
  logic [DEPTH-1:0] burst_q;
  logic [DEPTH-1:0] done_q;
  logic [PW-1:0]    wp_q, rp_q, fp_q;
  logic [CW-1:0]    occ_q;

  assign space_ok_o = (occ_q != CW'(DEPTH));
  assign occ_o      = occ_q;
  assign drn_valid  = done_q[rp_q];
  assign drain_o    = drn_valid && drn_ready;
  assign drn_addr   = addr_q[rp_q];
  assign drn_burst  = burst_q[rp_q];
  assign drn_words  = cnt_q[rp_q];

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign drn_data[g*DW +: DW] = data_q[rp_q][g];
    assign drn_be[g*BW +: BW]   = be_q[rp_q][g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      fp_q    <= '0;
      occ_q   <= '0;
      done_q  <= '0;
      burst_q <= '0;
    end else begin
      if (alloc_i) begin
        burst_q[wp_q] <= burst_i;
        fp_q          <= wp_q;
        wp_q          <= PW'(ptr_next(int'(wp_q), DEPTH));
      end
      if (word_we_i && last_i) done_q[fp_q] <= 1'b1;
      if (drain_o) begin
        done_q[rp_q] <= 1'b0;
        rp_q         <= PW'(ptr_next(int'(rp_q), DEPTH));
      end
      case ({alloc_i, drain_o})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i) begin
      addr_q[wp_q] <= addr_i;
      cnt_q[wp_q]  <= '0;
      for (int k = 0; k < WORDS; k++) begin
        data_q[wp_q][k] <= '0;
        be_q[wp_q][k]   <= '0;
      end
    end
    if (word_we_i) begin
      data_q[fp_q][lane_i] <= wdata_i;
      be_q[fp_q][lane_i]   <= wbe_i;
      cnt_q[fp_q]          <= cnt_q[fp_q] + 1'b1;
    end
  end

  // R1: never claim a slot beyond the fourth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (occ_q < CW'(DEPTH)));
  // R8: fill and drain together leave the count alone
  a_r8_occ_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && drain_o) |=> (occ_q == $past(occ_q)));
  // R7: only a fully written entry is shown
  a_r7_complete: assert property (@(posedge clk) disable iff (!rst_n)
    drn_valid |-> (drn_words == (drn_burst ? NW'(WORDS) : NW'(1))));
  // R10: a stalled head holds still
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_addr) && $stable(drn_data)));

endmodule

// File: rtl/wr_cmd_buf.sv
module wr_cmd_buf import wcb_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = BUS_W,
  localparam int BW   = DW / 8,
  localparam int NW   = $clog2(WORDS + 1),
  localparam int LW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int OFFB = $clog2(WORDS * BW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_cmd_valid,
  input  logic [1:0]          cpu_len,
  input  logic                cpu_dat_valid,
  input  logic [DW-1:0]       cpu_ad,
  input  logic [BW-1:0]       cpu_be,
  output logic                cpu_ready,
  output logic                cpu_unsup,
  output logic                drn_valid,
  input  logic                drn_ready,
  output logic [DW-1:0]       drn_addr,
  output logic                drn_burst,
  output logic [NW-1:0]       drn_words,
  output logic [WORDS*BW-1:0] drn_be,
  output logic [WORDS*DW-1:0] drn_data
);

  logic          alloc_w, burst_w, word_we_w, last_w, space_ok_w, drain_w;
  logic [LW-1:0] lane_w;
  logic [CW-1:0] occ_w;
  logic [DW-1:0] base_w;

  assign base_w = align_base(cpu_ad, burst_w, OFFB);

  wcb_ingest #(.WORDS(WORDS)) u_ingest (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cpu_cmd_valid),
    .cmd_len   (cpu_len),
    .dat_valid (cpu_dat_valid),
    .space_ok  (space_ok_w),
    .cpu_ready (cpu_ready),
    .cpu_unsup (cpu_unsup),
    .alloc_o   (alloc_w),
    .burst_o   (burst_w),
    .word_we_o (word_we_w),
    .lane_o    (lane_w),
    .last_o    (last_w)
  );

  wcb_store #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_i    (alloc_w),
    .burst_i    (burst_w),
    .addr_i     (base_w),
    .word_we_i  (word_we_w),
    .lane_i     (lane_w),
    .last_i     (last_w),
    .wdata_i    (cpu_ad),
    .wbe_i      (cpu_be),
    .space_ok_o (space_ok_w),
    .occ_o      (occ_w),
    .drain_o    (drain_w),
    .drn_valid  (drn_valid),
    .drn_ready  (drn_ready),
    .drn_addr   (drn_addr),
    .drn_burst  (drn_burst),
    .drn_words  (drn_words),
    .drn_be     (drn_be),
    .drn_data   (drn_data)
  );

  // R6: a refused command claims no slot
  a_r6_refused_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_unsup && !$past(drain_w)) |-> (occ_w == $past(occ_w)));

endmodule

// File: tb/wr_cmd_buf_test.sv
`timescale 1ns/1ps
module wr_cmd_buf_test;

  typedef struct packed {
    logic [31:0]  addr;
    logic         burst;
    logic [2:0]   words;
    logic [127:0] data;
    logic [15:0]  be;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_cmd_valid = 1'b0;
  logic [1:0] cpu_len = 2'd0;
  logic cpu_dat_valid = 1'b0;
  logic [31:0] cpu_ad = '0;
  logic [3:0] cpu_be = '0;
  logic cpu_ready, cpu_unsup, drn_valid, drn_burst;
  logic drn_ready;
  logic [31:0] drn_addr;
  logic [2:0] drn_words;
  logic [15:0] drn_be;
  logic [127:0] drn_data;

  logic rdy_fixed = 1'b0;
  logic rand_mode = 1'b0;
  logic rnd_bit = 1'b0;
  logic [15:0] lfsr_r = 16'hACE1;
  assign drn_ready = rand_mode ? rnd_bit : rdy_fixed;

  always #10 clk = ~clk;

  wr_cmd_buf uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_cmd_valid(cpu_cmd_valid), .cpu_len(cpu_len), .cpu_dat_valid(cpu_dat_valid),
    .cpu_ad(cpu_ad), .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_unsup(cpu_unsup),
    .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_addr(drn_addr),
    .drn_burst(drn_burst), .drn_words(drn_words), .drn_be(drn_be), .drn_data(drn_data)
  );

  // ---------------- behavioural reference ----------------
  ent_t doneq[$];
  ent_t cur;
  int   m_occ = 0;
  bit   m_fill = 0;
  int   m_lane = 0;
  bit   m_unsup = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      doneq.delete();
      m_occ = 0; m_fill = 0; m_lane = 0; m_unsup = 0; cur = '0;
    end else begin
      bit f0, e_ready, e_valid;
      f0 = m_fill;
      e_ready = (m_occ < 4) && !m_fill;
      e_valid = doneq.size() > 0;
      if (e_valid && drn_ready) begin
        void'(doneq.pop_front());
        m_occ--;
      end
      if (m_fill && cpu_dat_valid) begin
        cur.data[m_lane*32 +: 32] = cpu_ad;
        cur.be[m_lane*4 +: 4] = cpu_be;
        cur.words = cur.words + 3'd1;
        if (!cur.burst || m_lane == 3) begin
          doneq.push_back(cur);
          m_fill = 0;
        end
        m_lane++;
      end
      m_unsup = cpu_cmd_valid && !f0 && (cpu_len >= 2'd2);
      if (cpu_cmd_valid && e_ready && cpu_len < 2'd2) begin
        cur = '0;
        cur.burst = (cpu_len == 2'd1);
        cur.addr = cur.burst ? {cpu_ad[31:4], 4'h0} : cpu_ad;
        m_fill = 1; m_lane = 0; m_occ++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int nchk_a = 0, nbad_a = 0;
  task automatic cmp_a(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk_a++;
    if (act !== exp) begin
      nbad_a++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = doneq.size() > 0;
      cmp_a("R1 cpu_ready", 128'(cpu_ready), 128'((m_occ < 4) && !m_fill));
      cmp_a("R6 cpu_unsup", 128'(cpu_unsup), 128'(m_unsup));
      cmp_a("R7 drn_valid", 128'(drn_valid), 128'(ev));
      if (ev && drn_valid) begin
        cmp_a("R4 drn_addr", 128'(drn_addr), 128'(doneq[0].addr));
        cmp_a("R3 drn_burst", 128'(drn_burst), 128'(doneq[0].burst));
        cmp_a("R3 drn_words", 128'(drn_words), 128'(doneq[0].words));
        cmp_a("R2 drn_be", 128'(drn_be), 128'(doneq[0].be));
        cmp_a("R5 drn_data", drn_data, doneq[0].data);
      end
    end
  end

  always @(negedge clk) begin
    lfsr_r <= {lfsr_r[14:0], lfsr_r[15] ^ lfsr_r[13] ^ lfsr_r[12] ^ lfsr_r[10]};
    rnd_bit <= lfsr_r[3] | lfsr_r[7];
  end

  // ---------------- directed checks ----------------
  int nchk_d = 0, nbad_d = 0;
  bit finished = 0;
  task automatic chk_d(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk_d++;
    if (act !== exp) begin
      nbad_d++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [1:0] len, input logic [31:0] a, input logic [31:0] d0);
    int n;
    while (!cpu_ready) @(negedge clk);
    cpu_cmd_valid = 1'b1; cpu_len = len; cpu_ad = a;
    @(negedge clk);
    cpu_cmd_valid = 1'b0;
    n = (len == 2'd1) ? 4 : ((len == 2'd0) ? 1 : 0);
    for (int i = 0; i < n; i++) begin
      cpu_dat_valid = 1'b1; cpu_ad = d0 + i; cpu_be = 4'(15 - i);
      @(negedge clk);
    end
    cpu_dat_valid = 1'b0; cpu_ad = '0; cpu_be = '0;
  endtask

  task automatic flush();
    rdy_fixed = 1'b1;
    while (drn_valid || !cpu_ready) @(negedge clk);
    rdy_fixed = 1'b0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      $display("FAIL watchdog act=%0d exp=<150000", wd);
      $display("test done: total=%0d bad=%0d", nchk_a + nchk_d + 1, nbad_a + nbad_d + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_a;
    logic [127:0] hold_d;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk_d("R9 ready", 128'(cpu_ready), 128'(1));
    chk_d("R9 valid", 128'(drn_valid), 128'(0));
    chk_d("R9 unsup", 128'(cpu_unsup), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R3 aligned burst and R2 single, consumer stalled
    send(2'd1, 32'h0000_1238, 32'hA000_0000);
    send(2'd0, 32'h0000_5676, 32'h5555_0001);
    chk_d("R4 burst base", 128'(drn_addr), 128'(32'h0000_1230));
    chk_d("R3 words", 128'(drn_words), 128'(4));
    chk_d("R3 lane3", 128'(drn_data[127:96]), 128'(32'hA000_0003));
    chk_d("R3 lane0 be", 128'(drn_be[3:0]), 128'(4'hF));
    rdy_fixed = 1'b1; @(negedge clk); rdy_fixed = 1'b0;
    chk_d("R4 single addr", 128'(drn_addr), 128'(32'h0000_5676));
    chk_d("R2 words", 128'(drn_words), 128'(1));
    chk_d("R2 upper be", 128'(drn_be[15:4]), 128'(0));
    chk_d("R2 lane0", 128'(drn_data[31:0]), 128'(32'h5555_0001));
    flush();

    // R1 fill all four entries
    send(2'd1, 32'h0001_0000, 32'h1000_0000);
    send(2'd0, 32'h0002_0004, 32'h2000_0000);
    send(2'd1, 32'h0003_0010, 32'h3000_0000);
    send(2'd0, 32'h0004_0008, 32'h4000_0000);
    chk_d("R1 full ready", 128'(cpu_ready), 128'(0));
    // R10 stalled head
    hold_a = drn_addr; hold_d = drn_data;
    repeat (3) @(negedge clk);
    chk_d("R10 valid", 128'(drn_valid), 128'(1));
    chk_d("R10 addr", 128'(drn_addr), 128'(hold_a));
    chk_d("R10 data", drn_data, hold_d);
    // R6 refused codes while full
    cpu_cmd_valid = 1'b1; cpu_len = 2'd2; @(negedge clk);
    cpu_cmd_valid = 1'b0; cpu_len = 2'd0;
    chk_d("R6 unsup eight", 128'(cpu_unsup), 128'(1));
    chk_d("R6 still full", 128'(cpu_ready), 128'(0));
    @(negedge clk);
    chk_d("R6 unsup pulse", 128'(cpu_unsup), 128'(0));
    // R1 one drain reopens the bus the next cycle
    rdy_fixed = 1'b1; @(negedge clk); rdy_fixed = 1'b0;
    chk_d("R1 reopen", 128'(cpu_ready), 128'(1));
    chk_d("R7 fifo order", 128'(drn_addr), 128'(32'h0002_0004));
    // R8 command and drain in the same cycle
    cpu_cmd_valid = 1'b1; cpu_len = 2'd0; cpu_ad = 32'h0005_0000; rdy_fixed = 1'b1;
    @(negedge clk);
    cpu_cmd_valid = 1'b0; rdy_fixed = 1'b0;
    cpu_dat_valid = 1'b1; cpu_ad = 32'h5000_0000; cpu_be = 4'h3;
    @(negedge clk);
    cpu_dat_valid = 1'b0; cpu_ad = '0;
    chk_d("R8 occ three", 128'(cpu_ready), 128'(1));
    send(2'd0, 32'h0006_0000, 32'h6000_0000);
    chk_d("R8 now full", 128'(cpu_ready), 128'(0));
    // R6 reserved code
    cpu_cmd_valid = 1'b1; cpu_len = 2'd3; @(negedge clk);
    cpu_cmd_valid = 1'b0; cpu_len = 2'd0;
    chk_d("R6 unsup rsvd", 128'(cpu_unsup), 128'(1));
    flush();

    // random mix under random back-pressure
    rand_mode = 1'b1;
    for (int j = 0; j < 80; j++) begin
      logic [1:0] ln;
      ln = (lfsr_r[2:0] == 3'd0) ? 2'd2 : {1'b0, lfsr_r[5]};
      send(ln, {lfsr_r, lfsr_r[7:0], 8'(j)}, {8'(j), lfsr_r, 8'h00});
    end
    rand_mode = 1'b0;
    flush();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk_a + nchk_d, nbad_a + nbad_d);
    $finish;
  end

endmodule